// File: doc/BRIEF.md
# Many-Time-Programmable Byte Flash Model

This block is a synthesizable, clocked stand-in for a small byte-wide flash memory that can be reprogrammed many times. A sequencer under test drives it through the same strobes a device programmer would use: an address, a data byte, an active-low chip enable, an active-low output enable, and two flags. One flag stands for high voltage on the programming pin, the other for high voltage on the identification address line. All inputs are sampled on the rising edge of `clk`.

The model supports four operations. A normal read returns the stored byte. A single-pulse byte program can only clear bits. A single-pulse chip erase returns every byte to FFh. An identification read returns a fixed manufacturer byte or a device code, selected by address bit 0.

Each program or erase pulse is timed in clock cycles. A pulse that is too short, or that is broken off by a change of mode flags, leaves the array alone and raises a sticky error flag. The controller is a three-state machine:
- `ST_IDLE`: reads are served here.
- `ST_PGM`: a program pulse is being timed.
- `ST_ERS`: an erase pulse is being timed.

It has five named transitions:
- *start_pgm*: `ST_IDLE` to `ST_PGM`.
- *start_ers*: `ST_IDLE` to `ST_ERS`.
- *commit*: pulse end with sufficient width, back to `ST_IDLE` with the write performed.
- *reject*: pulse end with too few cycles, back to `ST_IDLE` with the error set.
- *abort*: mode flags changed mid-pulse, back to `ST_IDLE` with the error set.

Top module: `mtp_flash_model`

## Requirements
- R1: After reset every location reads FFh and `err_flag` is 0.
- R2: `dout_oe` is 1 only when the state is `ST_IDLE`, `ce_n`=0, `oe_n`=0 and `hv_pgm`=0. When `dout_oe` is 0 the output counts as high-impedance and `dout` reads 00h.
- R3: Program mode is `hv_pgm`=1, `hv_id`=0, `oe_n`=1. In this mode, a falling edge of `ce_n` latches `addr` and `din`. If `ce_n` is then seen low on at least PGM_CYC rising edges (the falling-edge sample included) before it is seen high, the latched location becomes old AND `din`. The write happens on the edge that sees `ce_n` high.
- R4: Programming never turns a 0 bit into a 1. Programming 0Fh and then F0h into an erased byte leaves 00h.
- R5: Erase mode is `hv_pgm`=1, `hv_id`=1, `oe_n`=1. A `ce_n` pulse seen low on at least ERS_CYC edges sets every location to FFh.
- R6: ID mode is `hv_pgm`=0, `hv_id`=1. In this mode, with `ce_n`=`oe_n`=0, `dout` is BFh when `addr[0]`=0 and DEV_CODE when `addr[0]`=1, whatever the other address bits are.
- R7: A program or erase pulse seen low on fewer edges than its limit leaves the array unchanged and sets `err_flag`.
- R8: `err_flag` stays 1 until reset, whatever operations follow.
- R9: If the mode flags or `oe_n` leave the pulse's mode while `ce_n` is still low, the operation ends without a write and `err_flag` is set.
- R10: A `ce_n` pulse in read mode (`hv_pgm`=0) changes no location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, array to FFh |
| addr | input | $clog2(DEPTH) | Byte address |
| din | input | 8 | Program data |
| ce_n | input | 1 | Chip enable, active low; its pulse times program/erase |
| oe_n | input | 1 | Output enable, active low |
| hv_pgm | input | 1 | Programming-pin high-voltage flag |
| hv_id | input | 1 | Identification-line high-voltage flag |
| dout | output | 8 | Read data (00h while not driven) |
| dout_oe | output | 1 | Tri-state enable for `dout` |
| err_flag | output | 1 | Sticky pulse error |

## Verification
Several properties are checked on every cycle:
- the output enable appears only under the read strobes and never during a timed pulse;
- the identification bytes are correct whenever they are driven;
- the error flag never falls outside reset.

Other behaviours need the bench's scenarios to be seen:
- the AND-only effect of programming on stored data;
- the exact pulse-width boundary at which a write is accepted;
- erase clearing the whole array;
- aborted and read-mode pulses leaving the contents untouched.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PGM,
        ST_ERS
    } mtp_state_t;

    typedef enum logic [2:0] {
        MD_READ,
        MD_ID,
        MD_PGM,
        MD_ERS,
        MD_INHIBIT
    } mtp_mode_t;

    localparam logic [7:0] MFR_BYTE = 8'hBF;

endpackage

// File: rtl/mtp_mode_decode.sv
module mtp_mode_decode
    import mtp_pkg::*;
(
    input  logic      hv_pgm,
    input  logic      hv_id,
    input  logic      oe_n,
    output mtp_mode_t mode
);

    always_comb begin
        if (!hv_pgm) begin
            mode = hv_id ? MD_ID : MD_READ;
        end else if (!oe_n) begin
            mode = MD_INHIBIT;
        end else begin
            mode = hv_id ? MD_ERS : MD_PGM;
        end
    end

endmodule

// File: rtl/mtp_pulse_timer.sv
module mtp_pulse_timer #(
    parameter int MAX_CYC = 100,
    localparam int CW = $clog2(MAX_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] TOP = CW'(MAX_CYC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(1);
        end else if (inc && cnt != TOP) begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/mtp_array.sv
module mtp_array #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          ers_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (ers_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/mtp_flash_model.sv
module mtp_flash_model
    import mtp_pkg::*;
#(
    parameter int         DEPTH    = 64,
    parameter logic [7:0] DEV_CODE = 8'hA3,
    parameter int         PGM_CYC  = 20,
    parameter int         ERS_CYC  = 100,
    localparam int        AW       = $clog2(DEPTH),
    localparam int        MAX_CYC  = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC,
    localparam int        CW       = $clog2(MAX_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          hv_pgm,
    input  logic          hv_id,
    output logic [7:0]    dout,
    output logic          dout_oe,
    output logic          err_flag
);

    localparam logic [CW-1:0] PGM_LIM = CW'(PGM_CYC);
    localparam logic [CW-1:0] ERS_LIM = CW'(ERS_CYC);

    mtp_state_t    state, state_nx;
    mtp_mode_t     mode;
    logic          ce_q;
    logic          ce_fall;
    logic          tmr_load, tmr_inc;
    logic [CW-1:0] cnt;
    logic          wr_en, ers_en, err_set;
    logic [AW-1:0] addr_l;
    logic [7:0]    din_l;
    logic [7:0]    rd_data;
    logic          busy;

    mtp_mode_decode u_dec (
        .hv_pgm (hv_pgm),
        .hv_id  (hv_id),
        .oe_n   (oe_n),
        .mode   (mode)
    );

    mtp_pulse_timer #(.MAX_CYC(MAX_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .inc   (tmr_inc),
        .cnt   (cnt)
    );

    mtp_array #(.DEPTH(DEPTH)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr_l),
        .wr_data (din_l),
        .ers_en  (ers_en),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    // chip-enable history for falling-edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q <= 1'b1;
        end else begin
            ce_q <= ce_n;
        end
    end

    assign ce_fall = ce_q & ~ce_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ce_fall && mode == MD_PGM) begin
                    state_nx = ST_PGM;             // start_pgm
                end else if (ce_fall && mode == MD_ERS) begin
                    state_nx = ST_ERS;             // start_ers
                end
            end
            ST_PGM: begin
                if (mode != MD_PGM || ce_n) begin
                    state_nx = ST_IDLE;            // abort / commit / reject
                end
            end
            ST_ERS: begin
                if (mode != MD_ERS || ce_n) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // per-state actions
    always_comb begin
        tmr_load = 1'b0;
        tmr_inc  = 1'b0;
        wr_en    = 1'b0;
        ers_en   = 1'b0;
        err_set  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                tmr_load = ce_fall && (mode == MD_PGM || mode == MD_ERS);
            end
            ST_PGM: begin
                if (mode != MD_PGM) begin
                    err_set = 1'b1;
                end else if (ce_n) begin
                    wr_en   = (cnt >= PGM_LIM);
                    err_set = (cnt <  PGM_LIM);
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            ST_ERS: begin
                if (mode != MD_ERS) begin
                    err_set = 1'b1;
                end else if (ce_n) begin
                    ers_en  = (cnt >= ERS_LIM);
                    err_set = (cnt <  ERS_LIM);
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // address and data captured at the start of a pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_l <= '0;
            din_l  <= 8'hFF;
        end else if (tmr_load) begin
            addr_l <= addr;
            din_l  <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (err_set) begin
            err_flag <= 1'b1;
        end
    end

    assign busy    = (state != ST_IDLE);
    assign dout_oe = !busy && !ce_n && !oe_n && (mode == MD_READ || mode == MD_ID);

    always_comb begin
        if (!dout_oe) begin
            dout = 8'h00;
        end else if (mode == MD_ID) begin
            dout = addr[0] ? DEV_CODE : MFR_BYTE;
        end else begin
            dout = rd_data;
        end
    end

endmodule

// File: rtl/mtp_flash_chk.sv
module mtp_flash_chk #(
    parameter logic [7:0] DEV_CODE = 8'hA3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       hv_pgm,
    input logic       hv_id,
    input logic       addr0,
    input logic [7:0] dout,
    input logic       dout_oe,
    input logic       err_flag,
    input logic       busy
);

    // R2
    oe_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!ce_n && !oe_n && !hv_pgm));

    // R2
    no_drive_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dout_oe);

    // R6
    id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && hv_id && !addr0) |-> dout == 8'hBF);

    // R6
    id_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && hv_id && addr0) |-> dout == DEV_CODE);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R2
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> dout == 8'h00);

endmodule

bind mtp_flash_model mtp_flash_chk #(.DEV_CODE(DEV_CODE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .hv_pgm   (hv_pgm),
    .hv_id    (hv_id),
    .addr0    (addr[0]),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .err_flag (err_flag),
    .busy     (busy)
);

// File: tb/test_mtp_flash_model.sv
module test_mtp_flash_model;

    localparam int         DEPTH    = 64;
    localparam int         AW       = $clog2(DEPTH);
    localparam logic [7:0] DEV_CODE = 8'hA5;
    localparam int         PGM_CYC  = 20;
    localparam int         ERS_CYC  = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'h00;
    logic          ce_n = 1'b1, oe_n = 1'b1, hv_pgm = 1'b0, hv_id = 1'b0;
    logic [7:0]    dout;
    logic          dout_oe, err_flag;

    int   total = 0;
    int   bad = 0;
    logic done = 1'b0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    mtp_flash_model #(
        .DEPTH(DEPTH), .DEV_CODE(DEV_CODE), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)
    ) i_mtp_flash_model (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
        .hv_pgm(hv_pgm), .hv_id(hv_id), .dout(dout), .dout_oe(dout_oe), .err_flag(err_flag)
    );

    function automatic logic [7:0] id_expect(logic [AW-1:0] a);
        return a[0] ? DEV_CODE : 8'hBF;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; hv_pgm = 1'b0; hv_id = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        @(negedge clk);
    endtask

    // pulse: ce_n low for n sampled edges in the chosen mode
    task automatic pulse(logic [AW-1:0] a, logic [7:0] d, logic id, int n);
        @(negedge clk);
        addr = a; din = d; hv_pgm = 1'b1; hv_id = id; oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (n) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        hv_pgm = 1'b0; hv_id = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(string req, logic [AW-1:0] a, logic id, logic [7:0] exp);
        @(negedge clk);
        addr = a; hv_pgm = 1'b0; hv_id = id; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        check(req, {7'd0, dout_oe}, 8'd1);
        check(req, dout, exp);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; hv_id = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        logic [7:0]    d;
        void'($urandom(32'd4242));
        do_reset();

        // R1: reset state
        check("R1 err", {7'd0, err_flag}, 8'd0);
        for (int i = 0; i < 8; i++) rd("R1 blank", AW'(i * 9), 1'b0, 8'hFF);

        // R2: no drive without both strobes
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1;
        check("R2 oe_n high", {7'd0, dout_oe}, 8'd0);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        check("R2 ce_n high", {7'd0, dout_oe}, 8'd0);
        ce_n = 1'b0; hv_pgm = 1'b1; #1;
        check("R2 hv_pgm", {7'd0, dout_oe}, 8'd0);
        ce_n = 1'b1; oe_n = 1'b1; hv_pgm = 1'b0;

        // R4: bits only clear
        pulse(AW'(5), 8'h0F, 1'b0, PGM_CYC);
        pulse(AW'(5), 8'hF0, 1'b0, PGM_CYC);
        model[5] = 8'h00;
        rd("R4 and", AW'(5), 1'b0, 8'h00);

        // R3: exact boundary commits
        pulse(AW'(9), 8'h5A, 1'b0, PGM_CYC);
        model[9] = 8'h5A;
        rd("R3 boundary", AW'(9), 1'b0, 8'h5A);

        // R3 / R4: random programming
        for (int k = 0; k < 40; k++) begin
            a = AW'($urandom % DEPTH);
            d = 8'($urandom);
            pulse(a, d, 1'b0, PGM_CYC + int'($urandom % 4));
            model[a] = model[a] & d;
        end
        for (int k = 0; k < 20; k++) begin
            a = AW'($urandom % DEPTH);
            rd("R3 random", a, 1'b0, model[a]);
        end
        check("R3 no err", {7'd0, err_flag}, 8'd0);

        // R6: ID read, other address bits ignored
        for (int k = 0; k < 6; k++) begin
            a = AW'($urandom % DEPTH);
            rd("R6 id", a, 1'b1, id_expect(a));
        end

        // R10: pulse in read mode
        @(negedge clk); addr = AW'(9); din = 8'h00; oe_n = 1'b1; ce_n = 1'b0;
        repeat (PGM_CYC + 5) @(negedge clk);
        ce_n = 1'b1;
        rd("R10 read-mode pulse", AW'(9), 1'b0, model[9]);

        // R9: abort mid pulse
        @(negedge clk); addr = AW'(9); din = 8'h00; hv_pgm = 1'b1; oe_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        repeat (PGM_CYC + 2) @(negedge clk);
        hv_pgm = 1'b0;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk);
        check("R9 err", {7'd0, err_flag}, 8'd1);
        rd("R9 unchanged", AW'(9), 1'b0, model[9]);

        // R1 again after reset
        do_reset();
        check("R1 err cleared", {7'd0, err_flag}, 8'd0);
        rd("R1 blank again", AW'(9), 1'b0, 8'hFF);

        // R7: short program pulse
        pulse(AW'(3), 8'h00, 1'b0, PGM_CYC - 1);
        check("R7 err", {7'd0, err_flag}, 8'd1);
        rd("R7 unchanged", AW'(3), 1'b0, 8'hFF);

        // R8: error survives good operations
        pulse(AW'(3), 8'h12, 1'b0, PGM_CYC + 1);
        model[3] = 8'h12;
        rd("R8 write ok", AW'(3), 1'b0, 8'h12);
        check("R8 sticky", {7'd0, err_flag}, 8'd1);

        // R7: short erase
        pulse(AW'(0), 8'h00, 1'b1, ERS_CYC - 1);
        rd("R7 erase short", AW'(3), 1'b0, 8'h12);

        // R5: full erase
        pulse(AW'(0), 8'h00, 1'b1, ERS_CYC);
        for (int i = 0; i < DEPTH; i++) rd("R5 erased", AW'(i), 1'b0, 8'hFF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule